// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the SD card clock from a faster reference clock. The clock passes through two dividers in series. The first is a power-of-two prescaler and the second is a linear divisor from 1 to 16. The total ratio is the product of the two. Software selects the two ratios with two small fields, each in an offset encoding, and turns the card clock on and off with one enable bit.

The configuration is latched only while the divider is stopped, so a frequency change takes the form disable, write, re-enable. When the enable drops, the output finishes the period in progress and then rests low, so no shortened pulse ever reaches the card. A ready flag reports when the clock is usable: it clears on disable or on any change of the fields, and it sets once two full periods of the output clock have completed.

Top module: `sdclk_divider`

## Requirements
- R1: The prescaler field `pre_fld` selects a ratio of twice the value of its highest set bit (value 0 gives ratio 1, 0x01 gives 2, 0x80 gives 256). Lower set bits beneath the highest one are ignored, so 0x06 gives ratio 8.
- R2: The divisor field `div_fld` gives a ratio of its value plus one (1 to 16). The total ratio N is the prescaler ratio times the divisor ratio.
- R3: For N of 2 or more, `card_clk` is high for floor(N/2) reference cycles and low for the remaining ceil(N/2) cycles of every period. Even ratios therefore give 50% duty, and for odd ratios the high phase is one reference cycle shorter.
- R4: With N = 1, `card_clk` follows the reference clock while enabled: one output rising edge for every reference rising edge.
- R5: Assume `clk_en` is set at a reference falling edge while the divider is stopped and N is 2 or more. `card_clk` is still low at the next falling edge and is high at the one after it.
- R6: After `clk_en` is cleared, `card_clk` completes its current period, then stays low for as long as `clk_en` stays low. With N = 1 no further rising edge appears once the stop has taken effect.
- R7: While the divider runs, changes to `pre_fld` or `div_fld` do not alter the output period. The new values take effect at the next start after a stop.
- R8: `clk_stable` is low on the first falling edge after `clk_en` is sampled low.
- R9: `clk_stable` is low on the first falling edge after either field changes value. If the divider keeps running, the flag sets again within three output periods.
- R10: After a start from stopped with unchanged fields, `clk_stable` is still low 2N reference cycles after the enable and is high one cycle later.
- R11: During and right after reset, `card_clk` and `clk_stable` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Card clock enable |
| pre_fld | input | 8 | Prescaler field (ratio shifted right by one) |
| div_fld | input | 4 | Divisor field (ratio minus one) |
| card_clk | output | 1 | Gated, divided card clock |
| clk_stable | output | 1 | Clock-usable flag |

## Verification
The divider is run with several ratio patterns, and each one separates a different fault. Small even and odd products (2, 3, 5, 6) expose duty-cycle rounding errors. The extremes (128, 256, 4096) expose counter width and wrap faults. A prescaler field with several bits set (0x06) shows whether only the highest bit is decoded. Ratio 1 exercises the pass-through path and its gating. Field writes made while the divider runs show whether the latched configuration stays frozen. The exact cycle at which the ready flag rises after a start separates a two-period count from an off-by-one count.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int SD_PRE_W     = 8;
  localparam int SD_DIV_W     = 4;
  localparam int SD_PRAT_W    = SD_PRE_W + 1;
  localparam int SD_DRAT_W    = SD_DIV_W + 1;
  localparam int SD_TOT_W     = SD_PRAT_W + SD_DRAT_W;
  localparam int SD_STB_PERIODS = 2;

  // Prescaler ratio: twice the weight of the highest set bit, or 1 when zero
  function automatic logic [SD_PRAT_W-1:0] pre_ratio(input logic [SD_PRE_W-1:0] f);
    logic [SD_PRAT_W-1:0] r;
    r = SD_PRAT_W'(1);
    for (int i = 0; i < SD_PRE_W; i++)
      if (f[i]) r = SD_PRAT_W'(2) << i;
    return r;
  endfunction

  function automatic logic [SD_DRAT_W-1:0] div_ratio(input logic [SD_DIV_W-1:0] f);
    return {1'b0, f} + SD_DRAT_W'(1);
  endfunction

  function automatic logic [SD_TOT_W-1:0] total_ratio(input logic [SD_PRAT_W-1:0] p,
                                                      input logic [SD_DRAT_W-1:0] d);
    return SD_TOT_W'(p) * SD_TOT_W'(d);
  endfunction

  // Position inside the output period, in reference cycles
  function automatic logic [SD_TOT_W-1:0] period_pos(input logic [SD_DRAT_W-1:0] dcnt,
                                                     input logic [SD_PRAT_W-1:0] pcnt,
                                                     input logic [SD_PRAT_W-1:0] p);
    return SD_TOT_W'(dcnt) * SD_TOT_W'(p) + SD_TOT_W'(pcnt);
  endfunction

  // High phase covers the first floor(N/2) reference cycles
  function automatic logic phase_high(input logic [SD_TOT_W-1:0] pos,
                                      input logic [SD_TOT_W-1:0] tot);
    return pos < (tot >> 1);
  endfunction
endpackage

// File: rtl/sdclk_prescaler.sv
module sdclk_prescaler #(
  parameter int CNT_W = 9
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] ratio,
  output logic             tick,
  output logic [CNT_W-1:0] cnt
);
  assign tick = run && (cnt == ratio - CNT_W'(1));

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/sdclk_divstage.sv
module sdclk_divstage #(
  parameter int CNT_W = 5
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] ratio,
  output logic             wrap,
  output logic [CNT_W-1:0] cnt
);
  assign wrap = tick && (cnt == ratio - CNT_W'(1));

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (wrap)   cnt <= '0;
    else if (tick)   cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/sdclk_stable.sv
module sdclk_stable #(
  parameter int PERIODS = 2
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic clear,
  input  logic period_end,
  output logic stable
);
  localparam int SC_W = $clog2(PERIODS + 1);
  logic [SC_W-1:0] seen_q;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)                                   seen_q <= '0;
    else if (clear)                               seen_q <= '0;
    else if (period_end && seen_q < SC_W'(PERIODS)) seen_q <= seen_q + SC_W'(1);
  end

  assign stable = (seen_q == SC_W'(PERIODS));
endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
  import sdclk_pkg::*;
#(
  parameter int PRE_W       = SD_PRE_W,
  parameter int DIV_W       = SD_DIV_W,
  parameter int STB_PERIODS = SD_STB_PERIODS
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic [PRE_W-1:0] pre_fld,
  input  logic [DIV_W-1:0] div_fld,
  output logic             card_clk,
  output logic             clk_stable
);
  localparam int PRAT_W = PRE_W + 1;
  localparam int DRAT_W = DIV_W + 1;
  localparam int TOT_W  = PRAT_W + DRAT_W;

  logic             run_q;
  logic [PRE_W-1:0] cfg_pre_q, pre_prev_q;
  logic [DIV_W-1:0] cfg_div_q, div_prev_q;
  logic             card_q;
  logic             byp_gate_q;

  // Named internal events
  logic [PRAT_W-1:0] pre_rat;
  logic [DRAT_W-1:0] div_rat;
  logic [TOT_W-1:0]  tot_rat;
  logic [PRAT_W-1:0] pcnt;
  logic [DRAT_W-1:0] dcnt;
  logic              pre_tick;
  logic              div_wrap;
  logic              period_end;
  logic              start_evt;
  logic              stop_evt;
  logic              fld_chg;
  logic              bypass;
  logic              stb_clear;

  assign pre_rat = pre_ratio(cfg_pre_q);
  assign div_rat = div_ratio(cfg_div_q);
  assign tot_rat = total_ratio(pre_rat, div_rat);
  assign bypass  = (tot_rat == TOT_W'(1));

  sdclk_prescaler #(.CNT_W(PRAT_W)) u_pre (
    .clk_ref(clk_ref), .rst_n(rst_n), .run(run_q),
    .ratio(pre_rat), .tick(pre_tick), .cnt(pcnt)
  );

  sdclk_divstage #(.CNT_W(DRAT_W)) u_div (
    .clk_ref(clk_ref), .rst_n(rst_n), .run(run_q), .tick(pre_tick),
    .ratio(div_rat), .wrap(div_wrap), .cnt(dcnt)
  );

  assign period_end = run_q && div_wrap;
  assign start_evt  = !run_q && clk_en;
  assign stop_evt   = period_end && !clk_en;
  assign fld_chg    = (pre_fld != pre_prev_q) || (div_fld != div_prev_q);
  assign stb_clear  = !clk_en || fld_chg || !run_q;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      cfg_pre_q  <= '0;
      cfg_div_q  <= '0;
      pre_prev_q <= '0;
      div_prev_q <= '0;
      card_q     <= 1'b0;
    end else begin
      if (start_evt)     run_q <= 1'b1;
      else if (stop_evt) run_q <= 1'b0;
      if (!run_q) begin
        cfg_pre_q <= pre_fld;
        cfg_div_q <= div_fld;
      end
      pre_prev_q <= pre_fld;
      div_prev_q <= div_fld;
      card_q     <= run_q && phase_high(period_pos(dcnt, pcnt, pre_rat), tot_rat);
    end
  end

  // Pass-through gate changes only while the reference clock is low
  always_ff @(negedge clk_ref or negedge rst_n) begin
    if (!rst_n) byp_gate_q <= 1'b0;
    else        byp_gate_q <= run_q && bypass;
  end

  assign card_clk = card_q | (clk_ref & byp_gate_q);

  sdclk_stable #(.PERIODS(STB_PERIODS)) u_stb (
    .clk_ref(clk_ref), .rst_n(rst_n), .clear(stb_clear),
    .period_end(period_end), .stable(clk_stable)
  );
endmodule

// File: rtl/sdclk_divider_chk.sv
module sdclk_divider_chk #(
  parameter int PRE_W = 8,
  parameter int DIV_W = 4
) (
  input logic             clk_ref,
  input logic             rst_n,
  input logic             clk_en,
  input logic             run_q,
  input logic             period_end,
  input logic             fld_chg,
  input logic [PRE_W-1:0] cfg_pre_q,
  input logic [DIV_W-1:0] cfg_div_q,
  input logic             card_q,
  input logic             clk_stable
);
  AST_STABLE_DROPS_ON_DISABLE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !clk_en |=> !clk_stable); // R8
  AST_STABLE_DROPS_ON_WRITE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    fld_chg |=> !clk_stable); // R9
  AST_CFG_FROZEN: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> ($stable(cfg_pre_q) && $stable(cfg_div_q))); // R7
  AST_STOP_AT_PERIOD_END: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(run_q) |-> $past(period_end)); // R6
  AST_STOPPED_LOW: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!run_q && $past(!run_q)) |-> !card_q); // R6
  AST_STABLE_NEEDS_RUN: assert property (@(posedge clk_ref) disable iff (!rst_n)
    clk_stable |-> run_q); // R10
endmodule

bind sdclk_divider sdclk_divider_chk #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_chk (
  .clk_ref(clk_ref), .rst_n(rst_n), .clk_en(clk_en), .run_q(run_q),
  .period_end(period_end), .fld_chg(fld_chg), .cfg_pre_q(cfg_pre_q),
  .cfg_div_q(cfg_div_q), .card_q(card_q), .clk_stable(clk_stable)
);

// File: tb/sdclk_divider_bench.sv
`timescale 1ns/1ps
module sdclk_divider_bench;
  logic       clk_ref = 1'b0;
  logic       rst_n   = 1'b0;
  logic       clk_en  = 1'b0;
  logic [7:0] pre_fld = '0;
  logic [3:0] div_fld = '0;
  logic       card_clk;
  logic       clk_stable;

  int n_chk  = 0;
  int n_fail = 0;
  int cur_n  = 1;
  int edge_cnt = 0;
  bit done = 0;

  always #2 clk_ref = ~clk_ref;
  always @(posedge card_clk) edge_cnt++;

  sdclk_divider u_sdclk_divider (
    .clk_ref(clk_ref), .rst_n(rst_n), .clk_en(clk_en), .pre_fld(pre_fld),
    .div_fld(div_fld), .card_clk(card_clk), .clk_stable(clk_stable)
  );

  function automatic int ref_ratio(input logic [7:0] p, input logic [3:0] d);
    int pr = 1;
    for (int i = 0; i < 8; i++) if (p[i]) pr = 2 * (1 << i);
    return pr * (int'(d) + 1);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic stop_div();
    @(negedge clk_ref) clk_en = 1'b0;
    repeat (cur_n + 4) @(negedge clk_ref);
  endtask

  // Start with new fields; checks the first edge (R5) and ready timing (R10)
  task automatic start_div(input logic [7:0] p, input logic [3:0] d);
    int n;
    n = ref_ratio(p, d);
    stop_div();
    pre_fld = p; div_fld = d;
    repeat (2) @(negedge clk_ref);
    clk_en = 1'b1;
    cur_n = n;
    if (n >= 2) begin
      @(negedge clk_ref);
      check(card_clk === 1'b0, "R5 low one cycle after enable", card_clk, 0);
      @(negedge clk_ref);
      check(card_clk === 1'b1, "R5 high two cycles after enable", card_clk, 1);
      repeat (2 * n - 2) @(negedge clk_ref);
    end else begin
      repeat (2 * n) @(negedge clk_ref);
    end
    check(clk_stable === 1'b0, "R10 ready not before two periods", clk_stable, 0);
    @(negedge clk_ref);
    check(clk_stable === 1'b1, "R10 ready after two periods", clk_stable, 1);
  endtask

  task automatic measure(input int n, input string tag);
    int h, l;
    do @(negedge clk_ref); while (card_clk !== 1'b0);
    do @(negedge clk_ref); while (card_clk !== 1'b1);
    h = 0; l = 0;
    while (card_clk === 1'b1) begin h++; @(negedge clk_ref); end
    while (card_clk === 1'b0) begin l++; @(negedge clk_ref); end
    check(h == n / 2, {tag, " high phase"}, h, n / 2);
    check(l == n - n / 2, {tag, " low phase"}, l, n - n / 2);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_ref);
    check(card_clk === 1'b0 && clk_stable === 1'b0, "R11 outputs in reset",
          int'(card_clk) + int'(clk_stable), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk_ref);
    check(card_clk === 1'b0 && clk_stable === 1'b0, "R11 outputs after reset",
          int'(card_clk) + int'(clk_stable), 0);
  endtask

  task automatic t_ratio(input logic [7:0] p, input logic [3:0] d, input string tag);
    start_div(p, d);
    measure(ref_ratio(p, d), tag);
  endtask

  task automatic t_bypass();
    start_div(8'h00, 4'h0);
    @(negedge clk_ref) edge_cnt = 0;
    repeat (40) @(negedge clk_ref);
    check(edge_cnt == 40, "R4 ratio one edges", edge_cnt, 40);
    stop_div();
    edge_cnt = 0;
    repeat (20) @(negedge clk_ref);
    check(edge_cnt == 0, "R6 ratio one silent when off", edge_cnt, 0);
  endtask

  task automatic t_disable();
    int highs;
    start_div(8'h01, 4'h2);
    @(negedge clk_ref) clk_en = 1'b0;
    @(negedge clk_ref);
    check(clk_stable === 1'b0, "R8 ready drops on disable", clk_stable, 0);
    repeat (cur_n + 3) @(negedge clk_ref);
    highs = 0;
    repeat (3 * cur_n) begin @(negedge clk_ref); if (card_clk !== 1'b0) highs++; end
    check(highs == 0, "R6 output rests low", highs, 0);
  endtask

  task automatic t_write_running();
    start_div(8'h01, 4'h2);
    @(negedge clk_ref) div_fld = 4'h5;
    @(negedge clk_ref);
    check(clk_stable === 1'b0, "R9 ready drops on write", clk_stable, 0);
    measure(6, "R7 running ignores write");
    repeat (3 * 6 + 4) @(negedge clk_ref);
    check(clk_stable === 1'b1, "R9 ready returns", clk_stable, 1);
    start_div(8'h01, 4'h5);
    measure(12, "R7 new fields after restart");
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_ref);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_ratio(8'h00, 4'h1, "R3 ratio 2");
    t_ratio(8'h00, 4'h2, "R3 odd ratio 3");
    t_ratio(8'h00, 4'h4, "R3 odd ratio 5");
    t_ratio(8'h01, 4'h2, "R2 ratio 6");
    t_ratio(8'h06, 4'h0, "R1 highest bit ratio 8");
    t_ratio(8'h04, 4'hF, "R2 ratio 128");
    t_ratio(8'h80, 4'h0, "R1 ratio 256");
    t_ratio(8'h80, 4'hF, "R2 ratio 4096");
    t_bypass();
    t_disable();
    t_write_running();
    done = 1;
    finish_run();
  end
endmodule